// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Register with Output Latch

The block turns a serial bit stream into a parallel word. Bits enter a chain of flip-flops one at a time on the rising edge of a shift clock. A second, independently clocked holding register copies the whole chain on the rising edge of a storage clock. The parallel outputs change only when that copy is made, so a new word can be shifted in while the previous word stays on the outputs.

The shift chain has an asynchronous active-low clear. The clear empties the chain and nothing else: the holding register keeps its value. An active-low output enable switches the parallel pins between driving the held word and floating. The last stage of the chain also appears on a cascade pin, and that pin is always driven. Wiring the cascade pin of one block to the serial input of the next builds a longer register from several blocks that share their clocks.

Inside the block the held word and a drive flag travel as plain signals. Only the top level turns them into three-state pins.

Top module: `sr_latch_chain`

## Requirements
- R1: On a rising `shift_clk` edge with `clr_n` high, stage n takes the old value of stage n-1 and stage 0 takes `ser_in`. Stage 0 is latched into `par_out[0]` and stage WIDTH-1 into `par_out[WIDTH-1]`.
- R2: On a rising `store_clk` edge the holding register takes the chain contents. Shift edges alone never change `par_out`.
- R3: While `clr_n` is low, every stage and `casc_out` are 0 at once, without any clock edge, and shift edges have no effect. A storage edge taken after a clear latches all zeros.
- R4: Asserting `clr_n` low leaves the holding register, and so the driven `par_out`, unchanged.
- R5: With `oe_n` high all `par_out` bits are high-impedance. With `oe_n` low they drive the held word.
- R6: `casc_out` is driven and follows the chain whatever the level of `oe_n`.
- R7: `casc_out` equals the last stage, so two blocks chained through it act as one 2×WIDTH register. The first bit shifted in ends up in the top bit of the far block.
- R8: When `shift_clk` and `store_clk` rise together, the holding register takes the chain state from before that edge, one shift behind.
- R9: Changing `oe_n` never changes the held word. Re-enabling the outputs shows the same value as before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Rising-edge clock of the shift chain |
| store_clk | input | 1 | Rising-edge clock of the holding register |
| clr_n | input | 1 | Asynchronous active-low clear of the shift chain only |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| par_out | output | WIDTH | Held word, high-impedance when disabled |
| casc_out | output | 1 | Last shift stage, always driven, for chaining |

## Verification
A shift and a storage capture can land on the same edge. The bench provokes this by raising both clocks in the same time step over several bits. The expected latched word is the chain model's value from before that step, never the freshly shifted one. A clear can also overlap a holding register that is being shown. The bench drops the clear between shift edges in the middle of a 16-bit load. It then expects a zero cascade output at once, and the parallel word left untouched until the next storage edge latches zeros.

// File: rtl/sr_latch_pkg.sv
package sr_latch_pkg;

    localparam int DEFAULT_WIDTH = 8;

    typedef enum logic {
        PAR_FLOAT = 1'b0,
        PAR_DRIVE = 1'b1
    } par_drive_e;

    function automatic par_drive_e drive_from_enable(input logic enable_n);
        return enable_n ? PAR_FLOAT : PAR_DRIVE;
    endfunction

endpackage

// File: rtl/sr_shift_stage.sv
module sr_shift_stage #(
    parameter int WIDTH = sr_latch_pkg::DEFAULT_WIDTH
) (
    input  logic             shift_clk,
    input  logic             clr_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages_o,
    output logic             tail_o
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d.stages = {chain_q.stages[TOP-1:0], ser_in};
    end

    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign stages_o = chain_q.stages;
    assign tail_o   = chain_q.stages[TOP];
endmodule

// File: rtl/sr_hold_stage.sv
module sr_hold_stage #(
    parameter int WIDTH = sr_latch_pkg::DEFAULT_WIDTH
) (
    input  logic             store_clk,
    input  logic [WIDTH-1:0] stages_i,
    output logic [WIDTH-1:0] held_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        hold_d.word = stages_i;
    end

    // No reset: content is undefined until the first storage edge.
    always_ff @(posedge store_clk) begin
        hold_q <= hold_d;
    end

    assign held_o = hold_q.word;
endmodule

// File: rtl/sr_drive_ctrl.sv
module sr_drive_ctrl (
    input  logic                     oe_n,
    output sr_latch_pkg::par_drive_e drive_o
);
    always_comb begin
        drive_o = sr_latch_pkg::drive_from_enable(oe_n);
    end
endmodule

// File: rtl/sr_latch_chain.sv
module sr_latch_chain #(
    parameter int WIDTH = sr_latch_pkg::DEFAULT_WIDTH
) (
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output wire  [WIDTH-1:0] par_out,
    output logic             casc_out
);
    import sr_latch_pkg::*;

    logic [WIDTH-1:0] stage_bits;
    logic [WIDTH-1:0] held_bits;
    logic             tail_bit;
    par_drive_e       drive;

    sr_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .stages_o  (stage_bits),
        .tail_o    (tail_bit)
    );

    sr_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .store_clk (store_clk),
        .stages_i  (stage_bits),
        .held_o    (held_bits)
    );

    sr_drive_ctrl u_drive (
        .oe_n    (oe_n),
        .drive_o (drive)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign par_out[i] = (drive == PAR_DRIVE) ? held_bits[i] : 1'bz;
    end

    assign casc_out = tail_bit;
endmodule

// File: rtl/sr_latch_chain_chk.sv
module sr_latch_chain_chk #(
    parameter int WIDTH = 8
) (
    input logic             shift_clk,
    input logic             store_clk,
    input logic             clr_n,
    input logic             ser_in,
    input logic             casc_out,
    input logic [WIDTH-1:0] stage_bits,
    input logic [WIDTH-1:0] held_bits
);
    // High once a shift edge has passed with no clear since.
    logic fresh_q;
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) fresh_q <= 1'b0;
        else        fresh_q <= 1'b1;
    end

    logic [WIDTH-1:0] snap_q;
    always_ff @(posedge store_clk) begin
        snap_q <= stage_bits;
    end

    // R1
    shift_moves_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        fresh_q |-> (stage_bits[WIDTH-1:1] == $past(stage_bits[WIDTH-2:0]))
                    && (stage_bits[0] == $past(ser_in)));

    // R3
    clear_zero_chk: assert property (@(posedge shift_clk) disable iff (clr_n)
        1'b1 |-> (stage_bits == '0) && (casc_out == 1'b0));

    // R7
    cascade_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        fresh_q |-> casc_out == $past(stage_bits[WIDTH-2]));

    // R2
    hold_copy_chk: assert property (@(negedge store_clk) disable iff (!clr_n)
        1'b1 |-> held_bits == snap_q);
endmodule

bind sr_latch_chain sr_latch_chain_chk #(.WIDTH(WIDTH)) u_chk (
    .shift_clk  (shift_clk),
    .store_clk  (store_clk),
    .clr_n      (clr_n),
    .ser_in     (ser_in),
    .casc_out   (casc_out),
    .stage_bits (stage_bits),
    .held_bits  (held_bits)
);

// File: tb/test_sr_latch_chain.sv
`timescale 1ns/1ps
module test_sr_latch_chain;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic ser = 1'b0, shift_clk = 1'b0, store_clk = 1'b0, clr_n = 1'b0, oe_n = 1'b1;
    wire [7:0] p0, p1;
    wire       c0, c1;
    // Pulls make a floating bus readable: dev0 floats to FF, dev1 to 00.
    pullup   pu0 [7:0] (p0);
    pulldown pd1 [7:0] (p1);

    sr_latch_chain i_sr_latch_chain (.ser_in(ser), .shift_clk(shift_clk), .store_clk(store_clk),
        .clr_n(clr_n), .oe_n(oe_n), .par_out(p0), .casc_out(c0));
    sr_latch_chain u_far (.ser_in(c0), .shift_clk(shift_clk), .store_clk(store_clk),
        .clr_n(clr_n), .oe_n(oe_n), .par_out(p1), .casc_out(c1));

    typedef struct {
        string      req;
        logic       chk_par;
        logic [15:0] par;
        logic       casc;
    } item_t;
    item_t q[$];

    int checks = 0, errors = 0;
    logic [15:0] m  = 16'h0;   // chain model
    logic [15:0] st = 16'h0;   // holding model

    // Monitor: pops expected items and compares at quiet times.
    initial forever begin
        item_t it;
        logic [15:0] obs;
        wait (q.size() != 0);
        #1;
        it  = q.pop_front();
        obs = {p1, p0};
        checks++;
        if (c1 !== it.casc) begin
            errors++;
            $display("FAIL %s casc_out got %b exp %b", it.req, c1, it.casc);
        end else if (it.chk_par && obs !== it.par) begin
            errors++;
            $display("FAIL %s par_out got %h exp %h", it.req, obs, it.par);
        end
    end

    task automatic expect_now(input string req, input logic chk_par);
        item_t it;
        it.req = req; it.chk_par = chk_par;
        it.par = oe_n ? 16'h00FF : st;
        it.casc = m[15];
        q.push_back(it);
        wait (q.size() == 0);
        #1;
    endtask

    task automatic shift_bit(input logic b);
        ser = b; #1;
        shift_clk = 1'b1;
        if (clr_n) m = {m[14:0], b};
        #2 shift_clk = 1'b0; #1;
    endtask

    task automatic store_pulse();
        #1 store_clk = 1'b1; st = m;
        #2 store_clk = 1'b0; #1;
    endtask

    task automatic both_pulse(input logic b);
        ser = b; #1;
        shift_clk = 1'b1; store_clk = 1'b1;
        st = m; m = {m[14:0], b};
        #2 shift_clk = 1'b0; store_clk = 1'b0; #1;
    endtask

    task automatic load_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #5;
        expect_now("R3 reset casc", 1'b0);
        shift_bit(1'b1);                        // clock during clear: ignored
        expect_now("R3 shift ignored in clear", 1'b0);
        clr_n = 1'b1; #2;

        load_word(16'hA5C3);
        expect_now("R6 casc while disabled", 1'b0);
        oe_n = 1'b0; #1;
        store_pulse();
        expect_now("R7 16-bit chain latch", 1'b1);
        oe_n = 1'b1; #1;
        expect_now("R5 outputs float", 1'b1);
        oe_n = 1'b0; #1;
        expect_now("R9 data kept across enable", 1'b1);

        shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
        expect_now("R2 shift leaves par_out", 1'b1);
        shift_bit(1'b0); shift_bit(1'b0);
        expect_now("R2 shift leaves par_out again", 1'b1);

        clr_n = 1'b0; m = 16'h0; #1;
        expect_now("R3 async clear mid-shift", 1'b1);
        expect_now("R4 clear keeps held word", 1'b1);
        clr_n = 1'b1; #2;
        store_pulse();
        expect_now("R3 latched zeros after clear", 1'b1);

        shift_bit(1'b1);
        store_pulse();
        expect_now("R1 stage0 to par bit 0", 1'b1);
        shift_bit(1'b0);
        store_pulse();
        expect_now("R1 bit moves to par bit 1", 1'b1);

        load_word(16'h3C5A);
        both_pulse(1'b1);
        expect_now("R8 tied clocks step 1", 1'b1);
        both_pulse(1'b0);
        expect_now("R8 tied clocks step 2", 1'b1);
        both_pulse(1'b1);
        expect_now("R8 tied clocks step 3", 1'b1);

        oe_n = 1'b1; #1;
        shift_bit(1'b1);
        expect_now("R6 casc follows while disabled", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule